// File: doc/BRIEF.md
# Hardware Debug Trigger Matcher

This block stores the settings of ten hardware debug triggers and evaluates them against every instruction fetch, load and store that the pipeline presents. A configuration port loads one trigger per cycle with an enable, a match type, a select bit, a timing bit, a chain bit and a compare value. Each cycle, every enabled trigger compares the address of the access kind it is wired to against its compare value.

The triggers form five fixed pairs, and pairwise chaining then decides which triggers fire. The block registers a per-trigger fire vector, an overall hit, and two flags. One flag says that a fired trigger wants the trap on the current instruction. The other says that a fired trigger wants it on the next instruction. The logic downstream turns these flags into the trap itself.

Top module: `trig_unit`

## Requirements
- R1: While reset is held and after it is released, every fire bit, `hit`, `trap_now` and `trap_next` are 0, and every trigger is disabled until it is written.
- R2: A write with `cfg_we` high and `cfg_idx` from 0 to 9 replaces that trigger's settings. The new settings are used for accesses sampled at the next clock edge and later. A write with `cfg_idx` from 10 to 15 changes no trigger.
- R3: Match types compare the address unsigned against the compare value. 0 means equal. 1 means masked match: the compare value's run of trailing one bits plus the zero bit above that run are don't-care bits. 2 means greater than or equal. 3 means less than.
- R4: The access kinds are wired as follows. Triggers 0, 1, 6 and 8 watch fetches (`fetch_pc`). Triggers 2, 3 and 7 watch stores (`store_addr`). Triggers 4, 5 and 9 watch loads (`load_addr`). A trigger can match only in a cycle where the valid input of its kind is high.
- R5: When its pair is unchained, a trigger fires on its own match. A disabled trigger never matches. A trigger whose select bit is 1 requests a data-value compare, which is not supported, so it never matches.
- R6: Pair p holds triggers 2p and 2p+1. Its chain setting is the chain bit of trigger 2p; the chain bit of trigger 2p+1 has no effect. In a chained pair, both triggers fire together only when both match on the same cycle. Otherwise neither fires.
- R7: In a chained pair whose two timing bits differ, neither trigger fires, even when both match.
- R8: When pair 1 (triggers 2 and 3, both watching stores) is chained, neither of its triggers ever fires.
- R9: Outputs are registered. An access sampled at clock edge k shows its result on the outputs from edge k until edge k+1.
- R10: `hit` is the OR of all fire bits. `trap_now` is high when a fired trigger has timing 0. `trap_next` is high when a fired trigger has timing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Trigger to write |
| cfg_enable | input | 1 | Trigger enable |
| cfg_mtype | input | 2 | Match type |
| cfg_select | input | 1 | 1 = data-value compare (never matches) |
| cfg_timing | input | 1 | 0 = current instruction, 1 = next |
| cfg_chain | input | 1 | Chain bit (effective on even triggers) |
| cfg_tdata | input | ADDR_W | Compare value |
| fetch_vld | input | 1 | Fetch access present |
| fetch_pc | input | ADDR_W | Fetch address |
| load_vld | input | 1 | Load access present |
| load_addr | input | ADDR_W | Load address |
| store_vld | input | 1 | Store access present |
| store_addr | input | ADDR_W | Store address |
| fire | output | 10 | Per-trigger fire vector |
| hit | output | 1 | Any trigger fired |
| trap_now | output | 1 | A fired trigger has timing 0 |
| trap_next | output | 1 | A fired trigger has timing 1 |

## Verification
The bench builds the block with the default 64-bit address width. This makes the masked-match corners at the top bits reachable: a compare value of all ones, and one with 63 trailing ones. Both of these match every address. With ten triggers fixed in five mixed pairs, a reference model that runs every cycle can exercise every chained pair against fetch, load and store traffic in the same cycle. Directed phases cover this, followed by a random phase that draws from a small address pool so that matches stay frequent.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int NUM_PAIRS = 5;
    localparam int NUM_TRIG  = 2 * NUM_PAIRS;
    localparam int IDX_W     = $clog2(NUM_TRIG);

    typedef enum logic [1:0] {
        MT_EQ    = 2'd0,
        MT_NAPOT = 2'd1,
        MT_GE    = 2'd2,
        MT_LT    = 2'd3
    } mtype_e;

    typedef enum logic [1:0] {
        AK_FETCH = 2'd0,
        AK_LOAD  = 2'd1,
        AK_STORE = 2'd2
    } akind_e;

    typedef struct packed {
        logic   enable;
        mtype_e mtype;
        logic   select;
        logic   timing;
        logic   chain;
    } trig_ctl_t;

    // Fixed wiring of each trigger slot to an access kind.
    function automatic akind_e trig_kind(input int t);
        case (t)
            0, 1, 6, 8: return AK_FETCH;
            2, 3, 7:    return AK_STORE;
            default:    return AK_LOAD;
        endcase
    endfunction
endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  trig_ctl_t                        wr_ctl,
    input  logic [ADDR_W-1:0]                wr_tdata,
    output trig_ctl_t [NUM_TRIG-1:0]         ctl_q,
    output logic [NUM_TRIG-1:0][ADDR_W-1:0]  tdata_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TRIG - 1);

    typedef struct packed {
        trig_ctl_t [NUM_TRIG-1:0]        ctl;
        logic [NUM_TRIG-1:0][ADDR_W-1:0] tdata;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (wr_idx <= LAST_IDX)) begin
            bank_d.ctl[wr_idx]   = wr_ctl;
            bank_d.tdata[wr_idx] = wr_tdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign ctl_q   = bank_q.ctl;
    assign tdata_q = bank_q.tdata;

    AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx > LAST_IDX)) |=> $stable(bank_q)); // R2
endmodule

// File: rtl/trig_match.sv
module trig_match
    import trig_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  trig_ctl_t          ctl,
    input  logic [ADDR_W-1:0]  tdata,
    input  logic               ev_vld,
    input  logic [ADDR_W-1:0]  ev_addr,
    output logic               match
);
    logic [ADDR_W-1:0] care_mask;
    logic              cmp;

    always_comb begin
        // Trailing ones and the zero above them become don't-care bits.
        care_mask = ~(tdata ^ (tdata + ADDR_W'(1)));
        case (ctl.mtype)
            MT_EQ:    cmp = (ev_addr == tdata);
            MT_NAPOT: cmp = (((ev_addr ^ tdata) & care_mask) == '0);
            MT_GE:    cmp = (ev_addr >= tdata);
            default:  cmp = (ev_addr <  tdata);
        endcase
        match = ctl.enable && !ctl.select && ev_vld && cmp;
    end
endmodule

// File: rtl/trig_pair_resolve.sv
module trig_pair_resolve
    import trig_pkg::*;
#(
    parameter bit STORE_PAIR = 1'b0
) (
    input  logic      m_even,
    input  logic      m_odd,
    input  trig_ctl_t ctl_even,
    input  trig_ctl_t ctl_odd,
    output logic      f_even,
    output logic      f_odd
);
    logic both;

    generate
        if (STORE_PAIR) begin : g_store
            always_comb begin
                both   = 1'b0;
                f_even = ctl_even.chain ? 1'b0 : m_even;
                f_odd  = ctl_even.chain ? 1'b0 : m_odd;
            end
        end else begin : g_mixed
            always_comb begin
                both   = m_even && m_odd && (ctl_even.timing == ctl_odd.timing);
                f_even = ctl_even.chain ? both : m_even;
                f_odd  = ctl_even.chain ? both : m_odd;
            end
        end
    endgenerate
endmodule

// File: rtl/trig_unit.sv
module trig_unit
    import trig_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_idx,
    input  logic                 cfg_enable,
    input  logic [1:0]           cfg_mtype,
    input  logic                 cfg_select,
    input  logic                 cfg_timing,
    input  logic                 cfg_chain,
    input  logic [ADDR_W-1:0]    cfg_tdata,
    input  logic                 fetch_vld,
    input  logic [ADDR_W-1:0]    fetch_pc,
    input  logic                 load_vld,
    input  logic [ADDR_W-1:0]    load_addr,
    input  logic                 store_vld,
    input  logic [ADDR_W-1:0]    store_addr,
    output logic [9:0]           fire,
    output logic                 hit,
    output logic                 trap_now,
    output logic                 trap_next
);
    typedef struct packed {
        logic [NUM_TRIG-1:0] fire;
        logic                hit;
        logic                now;
        logic                next;
    } out_t;

    trig_ctl_t                       wr_ctl;
    trig_ctl_t [NUM_TRIG-1:0]        ctl;
    logic [NUM_TRIG-1:0][ADDR_W-1:0] tdata;
    logic [NUM_TRIG-1:0]             ev_vld;
    logic [NUM_TRIG-1:0][ADDR_W-1:0] ev_addr;
    logic [NUM_TRIG-1:0]             match;
    logic [NUM_TRIG-1:0]             fire_c;
    logic [NUM_TRIG-1:0]             timing_v;
    out_t                            out_d, out_q;

    always_comb begin
        wr_ctl.enable = cfg_enable;
        wr_ctl.mtype  = mtype_e'(cfg_mtype);
        wr_ctl.select = cfg_select;
        wr_ctl.timing = cfg_timing;
        wr_ctl.chain  = cfg_chain;
    end

    trig_cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_ctl   (wr_ctl),
        .wr_tdata (cfg_tdata),
        .ctl_q    (ctl),
        .tdata_q  (tdata)
    );

    generate
        for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
            localparam akind_e KIND = trig_kind(t);
            if (KIND == AK_FETCH) begin : g_f
                assign ev_vld[t]  = fetch_vld;
                assign ev_addr[t] = fetch_pc;
            end else if (KIND == AK_STORE) begin : g_s
                assign ev_vld[t]  = store_vld;
                assign ev_addr[t] = store_addr;
            end else begin : g_l
                assign ev_vld[t]  = load_vld;
                assign ev_addr[t] = load_addr;
            end
            assign timing_v[t] = ctl[t].timing;

            trig_match #(.ADDR_W(ADDR_W)) u_match (
                .ctl     (ctl[t]),
                .tdata   (tdata[t]),
                .ev_vld  (ev_vld[t]),
                .ev_addr (ev_addr[t]),
                .match   (match[t])
            );

            AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !ctl[t].enable |=> !fire[t]); // R5
        end

        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam bit STP = (trig_kind(2*p) == AK_STORE) && (trig_kind(2*p+1) == AK_STORE);

            trig_pair_resolve #(.STORE_PAIR(STP)) u_pair (
                .m_even   (match[2*p]),
                .m_odd    (match[2*p+1]),
                .ctl_even (ctl[2*p]),
                .ctl_odd  (ctl[2*p+1]),
                .f_even   (fire_c[2*p]),
                .f_odd    (fire_c[2*p+1])
            );

            AST_CHAIN_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
                ctl[2*p].chain |=> (fire[2*p] == fire[2*p+1])); // R6
            AST_CHAIN_TIMING_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl[2*p].chain && (ctl[2*p].timing != ctl[2*p+1].timing))
                |=> (!fire[2*p] && !fire[2*p+1])); // R7
            if (STP) begin : g_stchk
                AST_STORE_CHAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                    ctl[2*p].chain |=> (!fire[2*p] && !fire[2*p+1])); // R8
            end
        end
    endgenerate

    always_comb begin
        out_d.fire = fire_c;
        out_d.hit  = |fire_c;
        out_d.now  = |(fire_c & ~timing_v);
        out_d.next = |(fire_c & timing_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fire      = out_q.fire;
    assign hit       = out_q.hit;
    assign trap_now  = out_q.now;
    assign trap_next = out_q.next;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_vld && !load_vld && !store_vld) |=> (fire == '0)); // R4
    AST_HIT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (trap_now || trap_next)); // R10
endmodule

// File: tb/trig_unit_bench.sv
module trig_unit_bench;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_idx = '0;
    logic          cfg_enable = 1'b0;
    logic [1:0]    cfg_mtype = '0;
    logic          cfg_select = 1'b0;
    logic          cfg_timing = 1'b0;
    logic          cfg_chain = 1'b0;
    logic [AW-1:0] cfg_tdata = '0;
    logic          fetch_vld = 1'b0, load_vld = 1'b0, store_vld = 1'b0;
    logic [AW-1:0] fetch_pc = '0, load_addr = '0, store_addr = '0;
    logic [9:0]    fire;
    logic          hit, trap_now, trap_next;

    always #2.5 clk = ~clk;

    trig_unit u_trig_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_enable(cfg_enable), .cfg_mtype(cfg_mtype), .cfg_select(cfg_select),
        .cfg_timing(cfg_timing), .cfg_chain(cfg_chain), .cfg_tdata(cfg_tdata),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .load_vld(load_vld),
        .load_addr(load_addr), .store_vld(store_vld), .store_addr(store_addr),
        .fire(fire), .hit(hit), .trap_now(trap_now), .trap_next(trap_next)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    bit            m_en [10];
    int            m_mt [10];
    bit            m_sel [10];
    bit            m_tim [10];
    bit            m_chn [10];
    logic [AW-1:0] m_td [10];
    logic [9:0]    e_fire = '0;
    bit            e_hit = 0, e_now = 0, e_next = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    function automatic bit addr_hit(input int t, input logic [AW-1:0] a);
        int n;
        case (m_mt[t])
            0: return a == m_td[t];
            1: begin
                n = 0;
                while (n < AW && m_td[t][n]) n++;
                if (n >= AW - 1) return 1;
                return (a >> (n + 1)) == (m_td[t] >> (n + 1));
            end
            2: return a >= m_td[t];
            default: return a < m_td[t];
        endcase
    endfunction

    function automatic bit ev_on(input int t, output logic [AW-1:0] a);
        if (t == 0 || t == 1 || t == 6 || t == 8) begin a = fetch_pc; return fetch_vld; end
        if (t == 2 || t == 3 || t == 7) begin a = store_addr; return store_vld; end
        a = load_addr;
        return load_vld;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_fire = '0; e_hit = 0; e_now = 0; e_next = 0;
            for (int t = 0; t < 10; t++) begin
                m_en[t] = 0; m_mt[t] = 0; m_sel[t] = 0; m_tim[t] = 0; m_chn[t] = 0; m_td[t] = '0;
            end
        end else begin
            bit m [10];
            logic [AW-1:0] a;
            for (int t = 0; t < 10; t++) begin
                bit v;
                v = ev_on(t, a);
                m[t] = m_en[t] && !m_sel[t] && v && addr_hit(t, a);
            end
            for (int p = 0; p < 5; p++) begin
                if (!m_chn[2*p]) begin
                    e_fire[2*p] = m[2*p]; e_fire[2*p+1] = m[2*p+1];
                end else if (p == 1) begin
                    e_fire[2*p] = 0; e_fire[2*p+1] = 0;
                end else begin
                    bit both;
                    both = m[2*p] && m[2*p+1] && (m_tim[2*p] == m_tim[2*p+1]);
                    e_fire[2*p] = both; e_fire[2*p+1] = both;
                end
            end
            e_hit = 0; e_now = 0; e_next = 0;
            for (int t = 0; t < 10; t++) if (e_fire[t]) begin
                e_hit = 1;
                if (m_tim[t]) e_next = 1; else e_now = 1;
            end
            if (cfg_we && cfg_idx < 10) begin
                m_en[cfg_idx] = cfg_enable; m_mt[cfg_idx] = int'(cfg_mtype);
                m_sel[cfg_idx] = cfg_select; m_tim[cfg_idx] = cfg_timing;
                m_chn[cfg_idx] = cfg_chain; m_td[cfg_idx] = cfg_tdata;
            end
        end
    end

    always @(negedge clk) begin
        chk(32'(fire), 32'(e_fire), "fire");
        chk(32'(hit), 32'(e_hit), "hit");
        chk(32'(trap_now), 32'(e_now), "trap_now");
        chk(32'(trap_next), 32'(e_next), "trap_next");
    end

    task automatic wr(input int idx, input bit en, input int mt, input bit sel,
                      input bit tim, input bit chn, input logic [AW-1:0] td);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_enable = en; cfg_mtype = 2'(mt);
        cfg_select = sel; cfg_timing = tim; cfg_chain = chn; cfg_tdata = td;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // one access cycle; outputs checked directly one edge later
    task automatic acc(input bit fv, input logic [AW-1:0] fa, input bit lv, input logic [AW-1:0] la,
                       input bit sv, input logic [AW-1:0] sa, input logic [9:0] exp_fire);
        @(negedge clk);
        fetch_vld = fv; fetch_pc = fa; load_vld = lv; load_addr = la;
        store_vld = sv; store_addr = sa;
        @(negedge clk);
        fetch_vld = 0; load_vld = 0; store_vld = 0;
        #1 chk(32'(fire), 32'(exp_fire), "directed fire");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(32'(fire), 0, "fire in reset");
        rst_n = 1;
        acc(1, 64'h0, 1, 64'h0, 1, 64'h0, 10'h000);

        cur_req = "R3_eq_R9";
        wr(0, 1, 0, 0, 0, 0, 64'h1000);
        acc(1, 64'h1000, 0, 0, 0, 0, 10'h001);
        acc(1, 64'h1004, 0, 0, 0, 0, 10'h000);
        cur_req = "R4_valid";
        acc(0, 64'h1000, 1, 64'h1000, 1, 64'h1000, 10'h000);

        cur_req = "R3_napot";
        wr(1, 1, 1, 0, 1, 0, 64'h20FF);
        acc(1, 64'h2000, 0, 0, 0, 0, 10'h002);
        acc(1, 64'h21FF, 0, 0, 0, 0, 10'h002);
        acc(1, 64'h2200, 0, 0, 0, 0, 10'h000);
        wr(1, 1, 1, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        acc(1, 64'hDEAD_BEEF_0000_0000, 0, 0, 0, 0, 10'h002);
        wr(1, 1, 1, 0, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF);
        acc(1, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 10'h002);
        wr(1, 0, 0, 0, 0, 0, 64'h0);

        cur_req = "R3_ge_lt";
        wr(4, 1, 2, 0, 0, 0, 64'h8000);
        wr(5, 1, 3, 0, 1, 0, 64'h8000);
        acc(0, 0, 1, 64'h8000, 0, 0, 10'h010);
        acc(0, 0, 1, 64'h7FFF, 0, 0, 10'h020);
        cur_req = "R10";
        #1 chk(32'(trap_next), 1, "trap_next");
        chk(32'(trap_now), 0, "trap_now");

        cur_req = "R6_chain";
        wr(6, 1, 0, 0, 0, 1, 64'h4000);
        wr(7, 1, 0, 0, 0, 0, 64'h5000);
        acc(1, 64'h4000, 0, 0, 1, 64'h5000, 10'h0C0);
        acc(1, 64'h4000, 0, 0, 0, 0, 10'h000);
        cur_req = "R7";
        wr(7, 1, 0, 0, 1, 0, 64'h5000);
        acc(1, 64'h4000, 0, 0, 1, 64'h5000, 10'h000);

        cur_req = "R8";
        wr(2, 1, 0, 0, 0, 1, 64'h6000);
        wr(3, 1, 0, 0, 0, 0, 64'h6000);
        acc(0, 0, 0, 0, 1, 64'h6000, 10'h000);
        cur_req = "R5_unchained";
        wr(2, 1, 0, 0, 0, 0, 64'h6000);
        acc(0, 0, 0, 0, 1, 64'h6000, 10'h00C);

        cur_req = "R5_select";
        wr(2, 1, 0, 1, 0, 0, 64'h6000);
        acc(0, 0, 0, 0, 1, 64'h6000, 10'h008);

        cur_req = "R6_odd_chain";
        wr(8, 1, 0, 0, 0, 0, 64'h9000);
        wr(9, 1, 0, 0, 0, 1, 64'hA000);
        acc(1, 64'h9000, 0, 0, 0, 0, 10'h100);

        cur_req = "R2_bad_idx";
        wr(12, 0, 0, 0, 0, 0, 64'h0);
        wr(10, 0, 0, 0, 0, 0, 64'h0);
        acc(0, 0, 1, 64'h8000, 0, 0, 10'h010);
        acc(1, 64'h1000, 0, 0, 0, 0, 10'h001);

        cur_req = "R4_R10_random";
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] pool [6];
            pool[0] = 64'h100; pool[1] = 64'h1FF; pool[2] = 64'h200;
            pool[3] = 64'h0FF; pool[4] = 64'h7FFF_FFFF_FFFF_FFFF; pool[5] = 64'h180;
            @(negedge clk);
            cfg_we = ($urandom_range(0, 3) == 0);
            cfg_idx = 4'($urandom_range(0, 15));
            cfg_enable = ($urandom_range(0, 4) != 0);
            cfg_mtype = 2'($urandom_range(0, 3));
            cfg_select = ($urandom_range(0, 7) == 0);
            cfg_timing = 1'($urandom_range(0, 1));
            cfg_chain = 1'($urandom_range(0, 1));
            cfg_tdata = pool[$urandom_range(0, 5)];
            fetch_vld = 1'($urandom_range(0, 1)); fetch_pc = pool[$urandom_range(0, 5)];
            load_vld = 1'($urandom_range(0, 1)); load_addr = pool[$urandom_range(0, 5)];
            store_vld = 1'($urandom_range(0, 1)); store_addr = pool[$urandom_range(0, 5)];
        end
        @(negedge clk);
        cfg_we = 0; fetch_vld = 0; load_vld = 0; store_vld = 0;
        repeat (2) @(negedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule